// File: doc/BRIEF.md
# Serial Character Aligner

This block sits behind a clock-and-data recovery stage. It takes the recovered serial bit stream at one bit per clock and rebuilds 10-bit characters from it. The word boundary comes from a free-running phase counter. The aligner can also look for the positive-disparity comma, which arrives as the seven bits 0,0,1,1,1,1,1 followed by three don't-care bits. When it finds one, it moves the boundary so that the comma is presented with its first bit at output bit 0.

The boundary is only ever moved by stretching the word period in progress, so no downstream latch ever sees a short period. The search is active only while the sync enable is high. With the enable low, a comma in the stream changes nothing: the phase, the data path and the flag are all left alone. The flag goes high together with the strobe that presents an aligned comma and stays high for that whole word period.

Top module: `rx_char_align`

## Requirements
- R1: Each strobed word holds ten consecutive received bits. Bit 0 is the earliest of them and bit 9 the latest.
- R2: A match needs exactly the seven-bit prefix 0,0,1,1,1,1,1 in arrival order, and the last three bits of the character are ignored. The inverted prefix (1,1,0,0,0,0,0) and a prefix with any bit changed are not matches.
- R3: The word presented with the flag is exactly the ten bits of the comma, with the comma's first bit at bit 0.
- R4: The sync flag rises only together with a word strobe. It holds for exactly the one word period that presents the comma and drops at the next strobe.
- R5: While sync enable is low, a comma produces no flag and leaves the strobe phase unchanged, so the strobe spacing stays at 10 clocks.
- R6: A comma found at the wrong phase moves the boundary by lengthening the period that contains it. The spacing from the previous strobe is 11 to 19 clocks, never fewer than 10.
- R7: Without realignment, the word strobe is a one-clock pulse every 10 clocks, and the word output is held between strobes.
- R8: The strobe that presents a detected comma comes 11 clock edges after the edge that samples the comma's tenth bit.
- R9: During reset all outputs are zero. The first strobe comes on the 10th clock edge after reset is released.
- R10: A comma that already lies on the current boundary is flagged without any change to the strobe spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data bit, one per clock |
| sync_en | input | 1 | Enables the comma search and realignment |
| char_out | output | 10 | Rebuilt character, bit 0 received first |
| char_vld | output | 1 | One-clock strobe marking a new character |
| sync_hit | output | 1 | High for the word period that presents an aligned comma |

## Verification
A wrong phase count shows up within one word period as strobes spaced 9 or 11 clocks apart. Every strobed word is also compared against the bench's record of the sent bits, so a wrong count corrupts the characters at the next strobe. A comparator that checks the wrong bits or the wrong polarity shows up as a missing or unwanted flag on the strobe 11 edges after the comma ends. It also shows up as a wrongly stretched period in the negative-comma and near-miss cases. A pending-flag state that is kept too long or cleared too early makes the flag change between strobes or miss its word period.

// File: rtl/rx_align_pkg.sv
package rx_align_pkg;
   // Character width in bits
   localparam int unsigned CHAR_W = 10;
   // Length of the fixed prefix that marks a positive-disparity comma
   localparam int unsigned MARK_W = 7;
   // Prefix, bit i = i-th bit in arrival order: 0,0,1,1,1,1,1
   localparam logic [MARK_W-1:0] POS_MARK = 7'b1111100;
endpackage

// File: rtl/ra_shift_win.sv
module ra_shift_win #(
   parameter int unsigned       WORD_W   = 10,
   parameter int unsigned       MARK_W   = 7,
   parameter logic [MARK_W-1:0] MARK_PAT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   output logic [WORD_W-1:0] ripe_word,
   output logic              mark_seen
);
   // Two character slots: the newer slot is searched and the older one is
   // handed out, so a comma found now is complete in the output slot
   // exactly WORD_W clocks later.
   localparam int unsigned SR_W = 2 * WORD_W;

   logic [SR_W-1:0]   sr_q;
   logic [MARK_W-1:0] bit_eq;

   if (MARK_W > WORD_W) begin : g_bad_mark
      $error("ra_shift_win: MARK_W must not exceed WORD_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {bit_in, sr_q[SR_W-1:1]};
   end

   // Oldest MARK_W bits of the search slot against the prefix
   for (genvar i = 0; i < MARK_W; i++) begin : g_cmp
      assign bit_eq[i] = (sr_q[WORD_W+i] == MARK_PAT[i]);
   end

   assign mark_seen = &bit_eq;
   assign ripe_word = sr_q[WORD_W-1:0];
endmodule

// File: rtl/ra_phase_ctr.sv
module ra_phase_ctr #(
   parameter int unsigned WORD_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic at_edge
);
   localparam int unsigned CW   = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam int unsigned LAST = WORD_W - 1;

   logic [CW-1:0] cnt_q;

   if (WORD_W < 2) begin : g_bad_w
      $error("ra_phase_ctr: WORD_W must be at least 2");
   end

   assign at_edge = (cnt_q == CW'(LAST));

   // A restart pushes the next boundary a full word away; it never pulls it in
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart || at_edge) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/ra_out_stage.sv
module ra_out_stage #(
   parameter int unsigned WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              mark_hit,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] word_q,
   output logic              vld_q,
   output logic              flag_q
);
   logic pend_q;

   // Remember a hit until the boundary that hands its character out
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (mark_hit) pend_q <= 1'b1;
      else if (boundary) pend_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         vld_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         vld_q <= boundary;
         if (boundary) begin
            word_q <= word_in;
            flag_q <= pend_q;
         end
      end
   end
endmodule

// File: rtl/rx_char_align.sv
module rx_char_align #(
   parameter int unsigned       WORD_W   = rx_align_pkg::CHAR_W,
   parameter int unsigned       MARK_W   = rx_align_pkg::MARK_W,
   parameter logic [MARK_W-1:0] MARK_PAT = rx_align_pkg::POS_MARK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_in,
   input  logic              sync_en,
   output logic [WORD_W-1:0] char_out,
   output logic              char_vld,
   output logic              sync_hit
);
   logic [WORD_W-1:0] ripe_word;
   logic              mark_seen;
   logic              mark_hit;
   logic              boundary;

   ra_shift_win #(
      .WORD_W  (WORD_W),
      .MARK_W  (MARK_W),
      .MARK_PAT(MARK_PAT)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_in   (ser_in),
      .ripe_word(ripe_word),
      .mark_seen(mark_seen)
   );

   // With the search off, nothing downstream can see a match
   assign mark_hit = sync_en & mark_seen;

   ra_phase_ctr #(.WORD_W(WORD_W)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(mark_hit),
      .at_edge(boundary)
   );

   ra_out_stage #(.WORD_W(WORD_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .boundary(boundary),
      .mark_hit(mark_hit),
      .word_in (ripe_word),
      .word_q  (char_out),
      .vld_q   (char_vld),
      .flag_q  (sync_hit)
   );
endmodule

// File: rtl/rx_char_align_chk.sv
module rx_char_align_chk #(
   parameter int unsigned       WORD_W   = 10,
   parameter int unsigned       MARK_W   = 7,
   parameter logic [MARK_W-1:0] MARK_PAT = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_en,
   input logic [WORD_W-1:0] char_out,
   input logic              char_vld,
   input logic              sync_hit
);
   localparam int unsigned GMAX = 4 * WORD_W;
   localparam int unsigned GW   = $clog2(GMAX + 1);
   localparam int unsigned OMAX = 2 * WORD_W;

   logic [GW-1:0] gap_q;
   logic [GW-1:0] off_q;
   logic          seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         off_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (char_vld)                 gap_q <= GW'(1);
         else if (gap_q != GW'(GMAX))  gap_q <= gap_q + 1'b1;
         if (char_vld) seen_q <= 1'b1;
         if (sync_en)                  off_q <= '0;
         else if (off_q != GW'(OMAX))  off_q <= off_q + 1'b1;
      end
   end

   AST_NO_SHORT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (char_vld && seen_q) |-> (gap_q >= GW'(WORD_W))) else $error("short word period"); // R6
   AST_BOUNDED_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (char_vld && seen_q) |-> (gap_q <= GW'(2 * WORD_W - 1))) else $error("over-long word period"); // R6
   AST_FLAG_HOLDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit |-> (char_out[MARK_W-1:0] == MARK_PAT)) else $error("flag without comma at bit 0"); // R3
   AST_FLAG_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_hit) |-> char_vld) else $error("flag rose off a strobe"); // R4
   AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !char_vld |-> $stable(sync_hit)) else $error("flag moved between strobes"); // R4
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      char_vld |=> !char_vld) else $error("strobe wider than one clock"); // R7
   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !char_vld |-> $stable(char_out)) else $error("word changed between strobes"); // R7
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (off_q >= GW'(OMAX)) |-> !sync_hit) else $error("flag while search disabled"); // R5
endmodule

bind rx_char_align rx_char_align_chk #(
   .WORD_W  (WORD_W),
   .MARK_W  (MARK_W),
   .MARK_PAT(MARK_PAT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sync_en (sync_en),
   .char_out(char_out),
   .char_vld(char_vld),
   .sync_hit(sync_hit)
);

// File: tb/rx_char_align_tb.sv
`timescale 1ns/1ps
module rx_char_align_tb;
   localparam int OFS = 32;
   // Bits listed with bit 0 sent first
   localparam logic [9:0] K_POS_A = 10'b0101111100; // 0,0,1,1,1,1,1,0,1,0
   localparam logic [9:0] K_POS_B = 10'b1011111100; // same prefix, other tail
   localparam logic [9:0] K_NEG   = 10'b1010000011; // 1,1,0,0,0,0,0,1,0,1
   localparam logic [9:0] K_NEAR  = 10'b1010111100; // 0,0,1,1,1,1,0,...

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_in = 1'b0;
   logic       sync_en = 1'b0;
   logic [9:0] char_out;
   logic       char_vld;
   logic       sync_hit;

   always #4 clk = ~clk;

   rx_char_align u_dut (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sync_en(sync_en),
      .char_out(char_out), .char_vld(char_vld), .sync_hit(sync_hit)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   int edge_n = 0;
   bit hist [0:4095];
   int last_strobe = 0;
   bit have_strobe = 1'b0;
   bit cur_flag = 1'b0;
   bit fill_b = 1'b0;
   int s_flags, s_min_gap, s_max_gap, flag_edge, flag_gap;
   logic [9:0] flag_word;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_stats();
      s_flags = 0; s_min_gap = 1000; s_max_gap = 0; flag_edge = -1; flag_gap = -1;
      flag_word = '0;
   endtask

   // Drive one bit, observe the outputs after the edge that samples it
   task automatic send(input bit b);
      logic [9:0] expw;
      int gap;
      ser_in = b;
      @(posedge clk);
      edge_n++;
      hist[edge_n + OFS] = b;
      #2;
      if (char_vld) begin
         for (int i = 0; i < 10; i++) expw[i] = hist[edge_n - 20 + i + OFS];
         chk(char_out == expw, "R1 word content", int'(char_out), int'(expw));
         gap = edge_n - last_strobe;
         if (have_strobe) begin
            if (gap < s_min_gap) s_min_gap = gap;
            if (gap > s_max_gap) s_max_gap = gap;
         end
         have_strobe = 1'b1;
         last_strobe = edge_n;
         cur_flag = sync_hit;
         if (sync_hit) begin
            s_flags++; flag_edge = edge_n; flag_word = char_out; flag_gap = gap;
         end
      end else if (sync_hit !== cur_flag) begin
         chk(1'b0, "R4 flag moved between strobes", int'(sync_hit), int'(cur_flag));
      end
   endtask

   task automatic send_fill(input int n);
      for (int i = 0; i < n; i++) begin
         send(fill_b);
         fill_b = ~fill_b;
      end
   endtask

   task automatic send_char(input logic [9:0] c);
      for (int i = 0; i < 10; i++) send(c[i]);
   endtask

   task automatic wait_strobe();
      send_fill(1);
      while (last_strobe != edge_n) send_fill(1);
   endtask

   task automatic scn_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      chk(char_out == '0, "R9 word zero in reset", int'(char_out), 0);
      chk(char_vld == 1'b0, "R9 strobe low in reset", int'(char_vld), 0);
      chk(sync_hit == 1'b0, "R9 flag low in reset", int'(sync_hit), 0);
      rst_n = 1'b1;
      edge_n = 0;
      while (!have_strobe && edge_n < 40) send_fill(1);
      chk(last_strobe == 10, "R9 first strobe edge", last_strobe, 10);
   endtask

   task automatic scn_stream();
      sync_en = 1'b0;
      clear_stats();
      for (int i = 0; i < 200; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         send(lfsr[0]);
      end
      chk(s_min_gap == 10, "R7 min spacing", s_min_gap, 10);
      chk(s_max_gap == 10, "R7 max spacing", s_max_gap, 10);
      chk(s_flags == 0, "R5 no flag with search off", s_flags, 0);
   endtask

   task automatic scn_misalign();
      int prev, e, exp_gap;
      sync_en = 1'b1;
      send_fill(30);
      wait_strobe();
      send_fill(3);
      clear_stats();
      send_char(K_POS_A);
      e = edge_n;
      prev = last_strobe;
      exp_gap = (e + 1 - prev == 10) ? 10 : e + 11 - prev;
      send_fill(25);
      chk(s_flags == 1, "R4 one flagged word", s_flags, 1);
      chk(flag_edge == e + 11, "R8 flag strobe edge", flag_edge, e + 11);
      chk(flag_word == K_POS_A, "R3 comma at bit 0", int'(flag_word), int'(K_POS_A));
      chk(flag_gap == exp_gap, "R6 stretched period", flag_gap, exp_gap);
      chk(flag_gap > 10, "R6 period longer than a word", flag_gap, 11);
      chk(cur_flag == 1'b0, "R4 flag drops next strobe", int'(cur_flag), 0);
      clear_stats();
      send_fill(40);
      chk(s_min_gap == 10 && s_max_gap == 10, "R7 spacing after realign", s_max_gap, 10);
   endtask

   task automatic scn_aligned();
      int e;
      sync_en = 1'b1;
      wait_strobe();
      send_fill(9);
      clear_stats();
      send_char(K_POS_B);
      e = edge_n;
      send_fill(30);
      chk(s_flags == 1, "R2 tail bits ignored", s_flags, 1);
      chk(flag_edge == e + 11, "R8 aligned flag edge", flag_edge, e + 11);
      chk(flag_word == K_POS_B, "R3 aligned comma word", int'(flag_word), int'(K_POS_B));
      chk(flag_gap == 10, "R10 no stretch when aligned", flag_gap, 10);
      chk(s_max_gap == 10, "R10 spacing unchanged", s_max_gap, 10);
   endtask

   task automatic scn_negative();
      sync_en = 1'b1;
      wait_strobe();
      send_fill(4);
      clear_stats();
      send_char(K_NEG);
      send_fill(23);
      send_char(K_NEAR);
      send_fill(30);
      chk(s_flags == 0, "R2 inverted and near-miss prefixes rejected", s_flags, 0);
      chk(s_min_gap == 10 && s_max_gap == 10, "R2 no realign on non-match", s_max_gap, 10);
   endtask

   task automatic scn_disabled();
      sync_en = 1'b0;
      wait_strobe();
      send_fill(5);
      clear_stats();
      send_char(K_POS_A);
      send_fill(30);
      chk(s_flags == 0, "R5 comma ignored with search off", s_flags, 0);
      chk(s_min_gap == 10 && s_max_gap == 10, "R5 phase untouched", s_min_gap, 10);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) hist[i] = 1'b0;
      clear_stats();
      scn_reset();
      scn_stream();
      scn_misalign();
      scn_aligned();
      scn_negative();
      scn_disabled();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 50000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", edge_n, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule